// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 12-bit byte virtual address into a 9-bit physical address on a machine with 32-byte pages. Addresses whose top two bits are zero belong to system space (the lowest kilobyte). Every other address is user space. The system page table sits at a fixed physical base. The user page table does not sit in physical memory: it lives inside system virtual space. So the walker must first map the location of the user entry before it can read that entry.

A client presents one address at a time on a valid/ready request port. The walker reads one-byte page table entries over a small synchronous read port, and memory returns data one cycle after it accepts an address. The walker then emits a single-cycle response. A good response carries the physical address together with the modified and access-control bits of the final entry. A fault response names the level whose entry was invalid and the virtual address that missed. Protection checks, caching of translations and updates to the modified bit are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. `req_ready` is 1 only while no walk is in progress. It falls in the cycle after a request is accepted and stays low until the response cycle has passed.
- R2: A system-space address (bits 11:10 equal 00) causes exactly one memory read, at physical address 0x1E0 plus the virtual page number (bits 11:5).
- R3: A user-space address first forms the entry's virtual address E = 0x380 + VPN (12 bits). The first read is at 0x1E0 + E[11:5]. If that entry is valid, the second read is at {that entry's frame number, E[4:0]}.
- R4: Every entry is one byte with this layout: bit 7 is valid, bit 6 is modified, bits 5:4 are access control, and bits 3:0 are the physical frame number.
- R5: On success `rsp_fault` is 0, `rsp_pa` = {frame number of the final entry, va[4:0]}, `rsp_mod` and `rsp_acc` copy bits 6 and 5:4 of the final entry, and `rsp_fault_va` is 0.
- R6: If the first entry of a walk is invalid, the walk stops with no further read. The response has `rsp_fault` = 1 and `rsp_fault_lvl` = 0. `rsp_fault_va` is the request address for a system walk, or E for a user walk.
- R7: If the user entry is invalid, the response has `rsp_fault` = 1, `rsp_fault_lvl` = 1 and `rsp_fault_va` = the request address. Every fault response drives `rsp_pa`, `rsp_mod` and `rsp_acc` to 0.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_addr` holds its value. The read data is taken in the cycle after the address is accepted, so any number of stalls is tolerated.
- R9: Each accepted request yields exactly one response, and `rsp_valid` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 12 | Virtual byte address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl | output | 1 | 0 = system entry invalid, 1 = user entry invalid |
| rsp_fault_va | output | 12 | Virtual address that missed |
| rsp_pa | output | 9 | Translated physical address |
| rsp_mod | output | 1 | Modified bit of the final entry |
| rsp_acc | output | 2 | Access-control bits of the final entry |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 9 | Physical byte address of the entry |
| mem_ready | input | 1 | Memory accepts the address this cycle |
| mem_rdata | input | 8 | Entry byte, valid the cycle after acceptance |

## Verification
Several properties are checked on every cycle: the read address stays stable through stalls, the response strobe lasts a single cycle, `req_ready` drops after acceptance, system-table reads fall inside the system table window, a fault response carries a zero physical address, and a good response keeps the page offset. The properties cannot show which addresses are read or how a fault is classified. Those are checked by the bench, which sweeps all 4096 virtual addresses against a computed memory image while `mem_ready` stalls in a fixed pattern. The bench compares the read count, the read addresses and every response field for each address.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W = 12,
  parameter int PA_W = 9,
  parameter int OFF_W = 5,
  parameter int PTE_W = 8,
  parameter logic [PA_W-1:0] SYS_BASE = 9'h1E0,
  parameter logic [VA_W-1:0] USR_BASE = 12'h380
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_fault_lvl,
  output logic [VA_W-1:0] rsp_fault_va,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_mod,
  output logic [1:0]      rsp_acc,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_ready,
  input  logic [PTE_W-1:0] mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  typedef enum logic [2:0] {ST_IDLE, ST_SREQ, ST_SDAT, ST_UREQ, ST_UDAT, ST_DONE} st_t;
  st_t st;

  logic [VA_W-1:0]  va_q, ent_va_q;
  logic             user_q;
  logic [PFN_W-1:0] sys_pfn_q;

  wire             pte_v   = mem_rdata[PTE_W-1];
  wire             pte_m   = mem_rdata[PTE_W-2];
  wire [1:0]       pte_a   = mem_rdata[PTE_W-3 -: 2];
  wire [PFN_W-1:0] pte_pfn = mem_rdata[PFN_W-1:0];

  wire [VPN_W-1:0] sys_vpn = user_q ? ent_va_q[VA_W-1:OFF_W] : va_q[VA_W-1:OFF_W];

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_DONE);
  assign mem_req   = (st == ST_SREQ) || (st == ST_UREQ);
  assign mem_addr  = (st == ST_UREQ) ? {sys_pfn_q, ent_va_q[OFF_W-1:0]}
                                     : SYS_BASE + PA_W'(sys_vpn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      va_q <= '0;
      ent_va_q <= '0;
      user_q <= 1'b0;
      sys_pfn_q <= '0;
      rsp_fault <= 1'b0;
      rsp_fault_lvl <= 1'b0;
      rsp_fault_va <= '0;
      rsp_pa <= '0;
      rsp_mod <= 1'b0;
      rsp_acc <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_va;
          user_q <= |req_va[VA_W-1:VA_W-2];
          ent_va_q <= USR_BASE + VA_W'(req_va[VA_W-1:OFF_W]);
          st <= ST_SREQ;
        end
        ST_SREQ: if (mem_ready) st <= ST_SDAT;
        ST_UREQ: if (mem_ready) st <= ST_UDAT;
        ST_SDAT, ST_UDAT: begin
          if (!pte_v) begin
            rsp_fault <= 1'b1;
            rsp_fault_lvl <= (st == ST_UDAT);
            rsp_fault_va <= (st == ST_SDAT && user_q) ? ent_va_q : va_q;
            rsp_pa <= '0;
            rsp_mod <= 1'b0;
            rsp_acc <= '0;
            st <= ST_DONE;
          end else if (st == ST_SDAT && user_q) begin
            sys_pfn_q <= pte_pfn;
            st <= ST_UREQ;
          end else begin
            rsp_fault <= 1'b0;
            rsp_fault_lvl <= 1'b0;
            rsp_fault_va <= '0;
            rsp_pa <= {pte_pfn, va_q[OFF_W-1:0]};
            rsp_mod <= pte_m;
            rsp_acc <= pte_a;
            st <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));
  a_r9_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r2_sys_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && st == ST_SREQ |-> mem_addr >= SYS_BASE);
  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && !rsp_mod && rsp_acc == '0);
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [11:0] req_va = 0;
  logic rsp_valid, rsp_fault, rsp_fault_lvl, rsp_mod;
  logic [11:0] rsp_fault_va;
  logic [8:0] rsp_pa;
  logic [1:0] rsp_acc;
  logic mem_req, mem_ready;
  logic [8:0] mem_addr;
  logic [7:0] mem_rdata = 0;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_fault_va(rsp_fault_va), .rsp_pa(rsp_pa),
    .rsp_mod(rsp_mod), .rsp_acc(rsp_acc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [512];
  int rd_total = 0;
  logic [8:0] last0 = 0, last1 = 0;
  int cyc = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  initial begin
    for (int a = 0; a < 512; a++) begin
      mem[a][7]   = ((a * 37 + 11) % 9) != 0;
      mem[a][6:0] = 7'((a * 29 + 3) % 128);
    end
  end

  initial mem_ready = 1;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      mem_rdata <= mem[mem_addr];
      last1 <= last0;
      last0 <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic walk(input logic [11:0] va);
    logic [6:0] vpn;
    logic [11:0] ev, e_fva;
    logic [8:0] a1, a2, e_pa;
    logic [7:0] s, u;
    int n, start, waited;
    bit e_fault, e_lvl, e_mod;
    logic [1:0] e_acc;
    vpn = va[11:5];
    ev = 12'h380 + {5'b0, vpn};
    a2 = 0;
    e_fault = 0; e_lvl = 0; e_fva = 0; e_pa = 0; e_mod = 0; e_acc = 0;
    if (va[11:10] == 2'b00) begin
      a1 = 9'h1E0 + {2'b0, vpn};
      s = mem[a1]; n = 1;
      if (!s[7]) begin e_fault = 1; e_fva = va; end
      else begin e_pa = {s[3:0], va[4:0]}; e_mod = s[6]; e_acc = s[5:4]; end
    end else begin
      a1 = 9'h1E0 + {2'b0, ev[11:5]};
      s = mem[a1]; n = 1;
      if (!s[7]) begin e_fault = 1; e_fva = ev; end
      else begin
        a2 = {s[3:0], ev[4:0]};
        u = mem[a2]; n = 2;
        if (!u[7]) begin e_fault = 1; e_lvl = 1; e_fva = va; end
        else begin e_pa = {u[3:0], va[4:0]}; e_mod = u[6]; e_acc = u[5:4]; end
      end
    end
    start = rd_total;
    req_va = va;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R1", $sformatf("va=%h ready act=%0d exp=0", va, req_ready));
    waited = 0;
    while (!rsp_valid && waited < 100 && !done) begin
      @(negedge clk);
      waited++;
    end
    if (!rsp_valid) begin
      check(0, "R9", $sformatf("va=%h no response act=0 exp=1", va));
      return;
    end
    if (e_fault)
      check(rsp_fault && rsp_fault_lvl == e_lvl && rsp_fault_va == e_fva && rsp_pa == 0 &&
            !rsp_mod && rsp_acc == 0, e_lvl ? "R7" : "R6",
            $sformatf("va=%h act f=%0d l=%0d fva=%h pa=%h exp f=1 l=%0d fva=%h pa=0",
                      va, rsp_fault, rsp_fault_lvl, rsp_fault_va, rsp_pa, e_lvl, e_fva));
    else
      check(!rsp_fault && rsp_pa == e_pa && rsp_mod == e_mod && rsp_acc == e_acc &&
            rsp_fault_va == 0, "R5 R4",
            $sformatf("va=%h act f=%0d pa=%h m=%0d a=%0d exp f=0 pa=%h m=%0d a=%0d",
                      va, rsp_fault, rsp_pa, rsp_mod, rsp_acc, e_pa, e_mod, e_acc));
    if (n == 1)
      check(rd_total - start == 1 && last0 == a1, va[11:10] == 0 ? "R2" : "R6",
            $sformatf("va=%h reads act=%0d@%h exp=1@%h", va, rd_total - start, last0, a1));
    else
      check(rd_total - start == 2 && last1 == a1 && last0 == a2, "R3",
            $sformatf("va=%h reads act=%0d@%h,%h exp=2@%h,%h", va, rd_total - start,
                      last1, last0, a1, a2));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9",
          $sformatf("va=%h after rsp act v=%0d r=%0d exp v=0 r=1", va, rsp_valid, req_ready));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1",
          $sformatf("reset act r=%0d v=%0d m=%0d exp 1 0 0", req_ready, rsp_valid, mem_req));
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 4096 && !done; v++) walk(12'(v));
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule